// File: doc/BRIEF.md
# Write Request Stream Formatter

This block takes one received write-class request and hands it to user logic on two independent valid/ready streams. The requester first writes the payload into an internal beat buffer, one 128-bit beat per write, with packet byte 0 in bits [127:120] of beat 0. It then pulses a start strobe alongside the header fields. The block packs the fields into a 115-bit header word. It computes how many payload beats the byte count needs and how many two-byte segments of the final beat are unused.

The header word goes out on the header stream. The first payload beat goes out on the payload stream in the same cycle, marked as start of packet. The last beat carries an end-of-packet mark and the empty segment count. Each stream holds its word until it is accepted and follows its own backpressure. A new request is taken only when both the header and the last payload beat of the current one have been accepted.

Top module: `wrq_stream_fmt`

## Requirements
- R1: The header word is packed as: byte count in [114:106], CRF in [104], priority in [103:102], transport type in [101:100], ftype in [99:96] (passed unchanged, 4'b0101 being write class), destination ID in [95:80], and the remaining request fields in [79:0].
- R2: Header bit [105] (virtual channel) is always 0.
- R3: When transport type is 2'b00 (8-bit IDs), header bits [95:88] are 0. For any other transport type all 16 destination ID bits pass through.
- R4: A request with byte count N > 0 produces ceil(N/16) payload beats, and beat i carries buffer entry i unchanged.
- R5: Header valid and payload valid both rise in the cycle after an accepted start. Start-of-packet is high on the first payload beat only.
- R6: End-of-packet is high on the final beat only. There, empty = ((16 - N mod 16) mod 16)/2 two-byte segments (40 bytes gives 4, 2 bytes gives 7, 32 bytes gives 0). Empty is 0 on every other beat.
- R7: A word moves only in a cycle with valid and ready both high. While a stream is stalled, its valid and data hold stable. Payload valid drops in the cycle after the final beat is accepted.
- R8: The two streams are independent: the header may be accepted and drop while payload beats continue, and the header may stay pending after the payload has finished.
- R9: busy is high from the cycle after an accepted start until both streams have finished. A start while busy is ignored and changes neither stream.
- R10: A byte count of 0 presents only the header; payload valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write one beat into the payload buffer |
| wrIdx | input | 5 | Buffer beat index for the write |
| wrData | input | 128 | Beat data, first byte in [127:120] |
| start | input | 1 | Launch a request (taken when not busy) |
| reqSize | input | 9 | Payload byte count |
| reqCrf | input | 1 | CRF flag |
| reqPrio | input | 2 | Priority |
| reqTt | input | 2 | Transport type |
| reqFtype | input | 4 | Format type |
| reqDestId | input | 16 | Destination ID |
| reqTail | input | 80 | Remaining header fields |
| busy | output | 1 | A request is in progress |
| hdValid | output | 1 | Header word valid |
| hdReady | input | 1 | Header accepted by user logic |
| hdData | output | 115 | Packed header word |
| pdValid | output | 1 | Payload beat valid |
| pdReady | input | 1 | Payload beat accepted by user logic |
| pdData | output | 128 | Payload beat |
| pdSop | output | 1 | First beat of packet |
| pdEop | output | 1 | Final beat of packet |
| pdEmpty | output | 3 | Unused two-byte segments in the final beat |

## Verification
The bench targets byte counts at the beat arithmetic edges. It uses 2 bytes (one beat, empty 7), 32 bytes (exact multiple, empty 0), 40 bytes (empty 4) and 510 bytes (all 32 buffer entries). An off-by-one beat count would add or lose a beat. A wrong empty formula would show on the end-of-packet beat. Long payload stalls check that a design does not advance or change data without ready. A header held pending after the payload ends, with a start pulsed meanwhile, catches designs that couple the streams or accept a second request early. A zero-length request and both transport types catch a spurious payload beat and wrong destination masking.

// File: rtl/wsf_pkg.sv
package wsf_pkg;
  typedef struct packed {
    logic load;     // capture a new request
    logic advance;  // payload beat accepted, step to next
  } wsf_strobe_t;
endpackage

// File: rtl/wsf_dpath.sv
module wsf_dpath import wsf_pkg::*; #(
  parameter int BEAT_BYTES = 16,
  parameter int SIZE_W     = 9,
  parameter int DEST_W     = 16,
  parameter int TAIL_W     = 80,
  localparam int BEAT_W    = 8 * BEAT_BYTES,
  localparam int LANE_W    = $clog2(BEAT_BYTES),
  localparam int IDX_W     = SIZE_W - LANE_W,
  localparam int EMPTY_W   = LANE_W - 1,
  localparam int HDR_W     = SIZE_W + 10 + DEST_W + TAIL_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  wsf_strobe_t        strobe,
  input  logic               wrEn,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [BEAT_W-1:0]  wrData,
  input  logic [SIZE_W-1:0]  reqSize,
  input  logic               reqCrf,
  input  logic [1:0]         reqPrio,
  input  logic [1:0]         reqTt,
  input  logic [3:0]         reqFtype,
  input  logic [DEST_W-1:0]  reqDestId,
  input  logic [TAIL_W-1:0]  reqTail,
  output logic               reqZero,
  output logic               isLast,
  output logic [HDR_W-1:0]   hdData,
  output logic [BEAT_W-1:0]  pdData,
  output logic [EMPTY_W-1:0] pdEmpty
);
  localparam int MAX_BEATS  = 1 << IDX_W;
  localparam int SHORT_ID_W = 8;

  logic [BEAT_W-1:0]  store [MAX_BEATS];
  logic [IDX_W-1:0]   beatIdx;
  logic [IDX_W-1:0]   lastIdx;
  logic [EMPTY_W-1:0] emptyReg;

  logic [SIZE_W-1:0]  sizeM1;
  logic [LANE_W-1:0]  padBytes;
  logic [DEST_W-1:0]  destOut;

  always_comb begin
    reqZero  = (reqSize == '0);
    sizeM1   = reqSize - 1'b1;
    padBytes = LANE_W'(0) - reqSize[LANE_W-1:0];
    destOut  = reqDestId;
    if (reqTt == 2'b00) destOut[DEST_W-1:SHORT_ID_W] = '0;
  end

  always_ff @(posedge clk) begin
    if (wrEn) store[wrIdx] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdData   <= '0;
      beatIdx  <= '0;
      lastIdx  <= '0;
      emptyReg <= '0;
    end else if (strobe.load) begin
      hdData   <= {reqSize, 1'b0, reqCrf, reqPrio, reqTt, reqFtype, destOut, reqTail};
      beatIdx  <= '0;
      lastIdx  <= IDX_W'(sizeM1 >> LANE_W);
      emptyReg <= EMPTY_W'(padBytes >> 1);
    end else if (strobe.advance) begin
      beatIdx  <= beatIdx + 1'b1;
    end
  end

  assign isLast  = (beatIdx == lastIdx);
  assign pdData  = store[beatIdx];
  assign pdEmpty = isLast ? emptyReg : '0;

  // R2: virtual channel bit never set
  a_r2_vc_zero: assert property (@(posedge clk) disable iff (!rstN)
    hdData[HDR_W-SIZE_W-1] == 1'b0);

  // R3: short-ID transport type implies cleared upper destination byte
  a_r3_short_id: assert property (@(posedge clk) disable iff (!rstN)
    (hdData[TAIL_W+DEST_W+5:TAIL_W+DEST_W+4] == 2'b00)
      |-> (hdData[TAIL_W+DEST_W-1:TAIL_W+SHORT_ID_W] == '0));

  // R4: beat index never passes the final beat
  a_r4_idx_bound: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |-> beatIdx <= lastIdx);
endmodule

// File: rtl/wsf_ctrl.sv
module wsf_ctrl import wsf_pkg::*; (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        reqZero,
  input  logic        isLast,
  input  logic        hdReady,
  input  logic        pdReady,
  output wsf_strobe_t strobe,
  output logic        busy,
  output logic        hdValid,
  output logic        pdValid,
  output logic        pdSop,
  output logic        pdEop
);
  logic hdPend, pdActive, sopFlag;
  logic hdAccept, pdAccept;

  assign busy           = hdPend | pdActive;
  assign hdAccept       = hdPend & hdReady;
  assign pdAccept       = pdActive & pdReady;
  assign strobe.load    = start & ~busy;
  assign strobe.advance = pdAccept;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdPend   <= 1'b0;
      pdActive <= 1'b0;
      sopFlag  <= 1'b0;
    end else if (strobe.load) begin
      hdPend   <= 1'b1;
      pdActive <= ~reqZero;
      sopFlag  <= 1'b1;
    end else begin
      if (hdAccept) hdPend <= 1'b0;
      if (pdAccept) begin
        sopFlag <= 1'b0;
        if (isLast) pdActive <= 1'b0;
      end
    end
  end

  assign hdValid = hdPend;
  assign pdValid = pdActive;
  assign pdSop   = pdActive & sopFlag;
  assign pdEop   = pdActive & isLast;

  // R10: zero-length request raises only the header
  a_r10_hdr_only: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && reqZero) |=> (hdValid && !pdValid));

  // R9: start while busy leaves the header pending
  a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rstN)
    (start && hdValid && !hdReady) |=> hdValid);
endmodule

// File: rtl/wrq_stream_fmt.sv
module wrq_stream_fmt import wsf_pkg::*; (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [4:0]   wrIdx,
  input  logic [127:0] wrData,
  input  logic         start,
  input  logic [8:0]   reqSize,
  input  logic         reqCrf,
  input  logic [1:0]   reqPrio,
  input  logic [1:0]   reqTt,
  input  logic [3:0]   reqFtype,
  input  logic [15:0]  reqDestId,
  input  logic [79:0]  reqTail,
  output logic         busy,
  output logic         hdValid,
  input  logic         hdReady,
  output logic [114:0] hdData,
  output logic         pdValid,
  input  logic         pdReady,
  output logic [127:0] pdData,
  output logic         pdSop,
  output logic         pdEop,
  output logic [2:0]   pdEmpty
);
  wsf_strobe_t strobe;
  logic reqZero, isLast;

  wsf_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .reqZero(reqZero), .isLast(isLast),
    .hdReady(hdReady), .pdReady(pdReady), .strobe(strobe), .busy(busy),
    .hdValid(hdValid), .pdValid(pdValid), .pdSop(pdSop), .pdEop(pdEop)
  );

  wsf_dpath #(.BEAT_BYTES(16), .SIZE_W(9), .DEST_W(16), .TAIL_W(80)) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrData(wrData), .reqSize(reqSize), .reqCrf(reqCrf), .reqPrio(reqPrio),
    .reqTt(reqTt), .reqFtype(reqFtype), .reqDestId(reqDestId), .reqTail(reqTail),
    .reqZero(reqZero), .isLast(isLast), .hdData(hdData), .pdData(pdData),
    .pdEmpty(pdEmpty)
  );

  // R7: stalled header holds
  a_r7_hd_hold: assert property (@(posedge clk) disable iff (!rstN)
    (hdValid && !hdReady) |=> (hdValid && $stable(hdData)));

  // R7: stalled payload beat holds
  a_r7_pd_hold: assert property (@(posedge clk) disable iff (!rstN)
    (pdValid && !pdReady) |=> (pdValid && $stable(pdData) && $stable(pdEop) && $stable(pdSop)));

  // R7: payload valid drops after final beat accepted
  a_r7_eop_drop: assert property (@(posedge clk) disable iff (!rstN)
    (pdValid && pdEop && pdReady) |=> !pdValid);

  // R4: a non-final accepted beat is followed by another beat
  a_r4_continue: assert property (@(posedge clk) disable iff (!rstN)
    (pdValid && !pdEop && pdReady) |=> (pdValid && !pdSop));

  // R5: first beat of a packet carries start-of-packet
  a_r5_sop_first: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pdValid) |-> (pdSop && hdValid));

  // R6: empty is zero away from the final beat
  a_r6_empty_final: assert property (@(posedge clk) disable iff (!rstN)
    (pdValid && !pdEop) |-> (pdEmpty == 3'd0));
endmodule

// File: tb/test_wrq_stream_fmt.sv
module test_wrq_stream_fmt;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [4:0] wrIdx = '0;
  logic [127:0] wrData = '0;
  logic start = 1'b0;
  logic [8:0] reqSize = '0;
  logic reqCrf = 1'b0;
  logic [1:0] reqPrio = '0, reqTt = '0;
  logic [3:0] reqFtype = '0;
  logic [15:0] reqDestId = '0;
  logic [79:0] reqTail = '0;
  logic busy, hdValid, pdValid, pdSop, pdEop;
  logic hdReady = 1'b0, pdReady = 1'b0;
  logic [114:0] hdData;
  logic [127:0] pdData;
  logic [2:0] pdEmpty;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wrq_stream_fmt i_wrq_stream_fmt (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .start(start), .reqSize(reqSize), .reqCrf(reqCrf), .reqPrio(reqPrio),
    .reqTt(reqTt), .reqFtype(reqFtype), .reqDestId(reqDestId), .reqTail(reqTail),
    .busy(busy), .hdValid(hdValid), .hdReady(hdReady), .hdData(hdData),
    .pdValid(pdValid), .pdReady(pdReady), .pdData(pdData), .pdSop(pdSop),
    .pdEop(pdEop), .pdEmpty(pdEmpty)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] beatVal(input logic [7:0] seed, input int b);
    logic [127:0] v;
    for (int j = 0; j < 16; j++) v[127-8*j -: 8] = seed + 8'(16*b + j);
    return v;
  endfunction

  function automatic logic [114:0] expHdr(input logic [8:0] sz, input logic crf,
      input logic [1:0] pr, input logic [1:0] tt, input logic [3:0] ft,
      input logic [15:0] dst, input logic [79:0] tl);
    logic [15:0] d;
    d = (tt == 2'b00) ? {8'h00, dst[7:0]} : dst;
    return {sz, 1'b0, crf, pr, tt, ft, d, tl};
  endfunction

  task automatic fill(input int n, input logic [7:0] seed);
    for (int b = 0; b < n; b++) begin
      wrEn = 1'b1; wrIdx = 5'(b); wrData = beatVal(seed, b);
      @(negedge clk);
    end
    wrEn = 1'b0;
  endtask

  task automatic launch(input logic [8:0] sz, input logic [1:0] tt, input logic [15:0] dst);
    reqSize = sz; reqCrf = 1'b1; reqPrio = 2'b10; reqTt = tt;
    reqFtype = 4'b0101; reqDestId = dst; reqTail = {16'hC0DE, 64'h0123_4567_89AB_CDEF};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // drains n beats with pdReady high, starting on beat 0
  task automatic drain(input int n, input logic [7:0] seed, input logic [2:0] expEmpty);
    for (int b = 0; b < n; b++) begin
      chk("R4 beat valid", 128'(pdValid), 128'd1);
      chk("R4 beat data", pdData, beatVal(seed, b));
      chk("R5 sop", 128'(pdSop), 128'(b == 0));
      chk("R6 eop", 128'(pdEop), 128'(b == n-1));
      chk("R6 empty", 128'(pdEmpty), (b == n-1) ? 128'(expEmpty) : 128'd0);
      @(negedge clk);
    end
    chk("R7 valid drops after last", 128'(pdValid), 128'd0);
  endtask

  task automatic tReset();
    chk("R9 reset busy", 128'(busy), 128'd0);
    chk("R7 reset hdValid", 128'(hdValid), 128'd0);
    chk("R7 reset pdValid", 128'(pdValid), 128'd0);
  endtask

  task automatic tForty();
    fill(3, 8'h00);
    hdReady = 1'b1; pdReady = 1'b1;
    launch(9'd40, 2'b00, 16'h77DD);
    chk("R5 hdValid with first beat", 128'(hdValid), 128'd1);
    chk("R1 header pack", 128'(hdData), 128'(expHdr(9'd40, 1'b1, 2'b10, 2'b00, 4'b0101, 16'h77DD, reqTail)));
    chk("R3 short id upper byte", 128'(hdData[95:88]), 128'h00);
    chk("R2 vc bit", 128'(hdData[105]), 128'd0);
    chk("R1 ftype", 128'(hdData[99:96]), 128'h5);
    chk("R1 size field", 128'(hdData[114:106]), 128'd40);
    drain(3, 8'h00, 3'd4);
    chk("R8 header gone", 128'(hdValid), 128'd0);
    chk("R9 idle after", 128'(busy), 128'd0);
  endtask

  task automatic tHeaderLate();
    logic [114:0] held;
    fill(2, 8'h40);
    hdReady = 1'b0; pdReady = 1'b1;
    launch(9'd32, 2'b01, 16'hABCD);
    chk("R3 full dest id", 128'(hdData[95:80]), 128'hABCD);
    held = hdData;
    drain(2, 8'h40, 3'd0);
    chk("R8 header still pending", 128'(hdValid), 128'd1);
    chk("R9 busy while header pending", 128'(busy), 128'd1);
    reqSize = 9'd2; reqTt = 2'b11; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 start ignored header", 128'(hdData), 128'(held));
    chk("R9 start ignored payload", 128'(pdValid), 128'd0);
    hdReady = 1'b1;
    @(negedge clk);
    chk("R7 header taken", 128'(hdValid), 128'd0);
    chk("R9 idle", 128'(busy), 128'd0);
  endtask

  task automatic tStall();
    fill(3, 8'h90);
    hdReady = 1'b1; pdReady = 1'b0;
    launch(9'd48, 2'b00, 16'h0012);
    @(negedge clk);
    chk("R8 header accepted alone", 128'(hdValid), 128'd0);
    repeat (3) @(negedge clk);
    chk("R7 stalled valid", 128'(pdValid), 128'd1);
    chk("R7 stalled data", pdData, beatVal(8'h90, 0));
    chk("R7 stalled sop", 128'(pdSop), 128'd1);
    pdReady = 1'b1;
    drain(3, 8'h90, 3'd0);
  endtask

  task automatic tZero();
    hdReady = 1'b0; pdReady = 1'b1;
    launch(9'd0, 2'b00, 16'h0005);
    chk("R10 header only valid", 128'(hdValid), 128'd1);
    chk("R10 no payload", 128'(pdValid), 128'd0);
    chk("R10 busy", 128'(busy), 128'd1);
    hdReady = 1'b1;
    @(negedge clk);
    chk("R10 done", 128'(busy), 128'd0);
    chk("R10 still no payload", 128'(pdValid), 128'd0);
  endtask

  task automatic tTwo();
    fill(1, 8'hE0);
    hdReady = 1'b1; pdReady = 1'b1;
    launch(9'd2, 2'b00, 16'h0001);
    drain(1, 8'hE0, 3'd7);
  endtask

  task automatic tMax();
    fill(32, 8'h11);
    hdReady = 1'b1; pdReady = 1'b1;
    launch(9'd510, 2'b01, 16'hFEDC);
    chk("R1 max header", 128'(hdData), 128'(expHdr(9'd510, 1'b1, 2'b10, 2'b01, 4'b0101, 16'hFEDC, reqTail)));
    drain(32, 8'h11, 3'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tForty();
    tHeaderLate();
    tStall();
    tZero();
    tTwo();
    tMax();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule